// File: doc/BRIEF.md
# Programmable-Width Sample Input Assembler

This block sits at the front of a converter datapath. An upstream source drives a parallel bus one beat at a time, and the block builds datapath samples from those beats. The physical bus can be programmed to 4, 8, 16 or 32 bits. Each sample is an 8-bit or 16-bit word, either real or complex. A complex sample is an I word and a Q word. The block also makes the two pacing signals for the source: a data clock divided down from the converter clock, and a frame-sync strobe that asks for the first beat of each new sample.

A mode input selects one of two configurations. The multi-channel configuration allows every combination of width and format that the checker accepts, and up to four channels. The upconverter configuration fixes the interface at a 32-bit bus carrying one channel of 16-bit complex samples, and it ignores the other configuration inputs. Assembled samples come out with a valid strobe and a channel index. A configuration that does not match the first enabled downstream stage raises an error and holds the block idle. A divider ratio that is too small for the chosen widths does the same.

Top module: `sample_input_assembler`

## Requirements
- R1: While reset is held with enable low, dco, fsync, smp_valid and smp_ch are all 0.
- R2: In the multi-channel mode (upconv_mode = 0), cfg_err is 1 unless the format matches first_stage. The codes are: 0 is the symbol encoder and needs 8-bit real, 1 is the pulse-shaping filter and needs 8-bit complex, 2 means both stages are bypassed and needs 16-bit complex, and 3 is always an error. word16 = 1 selects 16-bit words and cplx = 1 selects complex.
- R3: While en is 0 or cfg_err is 1, dco, fsync and smp_valid stay 0, and all partial beats, pending samples and counters are discarded.
- R4: With ratio R = div_ratio, the data clock repeats every R converter cycles. dco is high for the first floor(R/2) cycles of each period. A bus beat is captured on the last cycle of the period.
- R5: The bus width is 4 << bus_sel bits. Bus bits above that width are ignored. When a sample is wider than the bus, its beats are packed least-significant beat first.
- R6: fsync is high for the whole data-clock period whose closing capture takes the first beat of a sample.
- R7: When the bus is wider than a sample, the B/S samples in one beat come out lowest first, on consecutive converter cycles. The first one appears in the cycle right after the capture edge. A sample that takes one or more whole beats appears in the cycle after its last beat is captured.
- R8: In complex format, smp_i is the lower word and smp_q the upper word of the sample. In real format, smp_q is 0. 8-bit words are zero-extended into the 16-bit outputs.
- R9: smp_ch starts at 0 and advances by one on each valid sample, wrapping after channel nch_m1 (1 to 4 active channels).
- R10: With upconv_mode = 1, the block acts as a 32-bit bus with one channel of 16-bit complex samples, whatever the values of bus_sel, word16, cplx, first_stage and nch_m1.
- R11: In any cycle where a configuration input differs from its value in the previous cycle, the block acts as disabled, so it flushes and then restarts with a fresh data-clock period.
- R12: cfg_err is also 1 when div_ratio is below 2, or below the number of samples that one bus beat holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable |
| upconv_mode | input | 1 | 1 selects the fixed single-channel upconverter configuration |
| bus_sel | input | 2 | Bus width code: width is 4 << bus_sel |
| word16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cplx | input | 1 | 1 selects complex samples, 0 selects real |
| first_stage | input | 2 | First enabled downstream stage: 0 encoder, 1 shaping filter, 2 bypass |
| nch_m1 | input | CH_W | Number of active channels minus one |
| div_ratio | input | DIV_W | Converter cycles per data-clock period |
| bus_data | input | BUS_W | Input data bus |
| dco | output | 1 | Divided data clock for the source |
| fsync | output | 1 | Request for the first beat of a new sample |
| smp_valid | output | 1 | Sample output valid |
| smp_i | output | WORD_W | Real or in-phase word |
| smp_q | output | WORD_W | Quadrature word, 0 for real data |
| smp_ch | output | CH_W | Channel index of the sample |
| cfg_err | output | 1 | Configuration is inconsistent |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a sample. With a 4-bit bus and 16-bit complex words, a sample spans eight beats. A partial accumulator and a running channel count only show up if the configuration moves after a number of cycles that is not a multiple of the sample period. The stimulus runs for an odd count of cycles before it changes the channel count, and again before it changes the ratio. The reference model must then see the dead cycle, the restart of fsync and the channel index back at 0. A second hard case is ratio equal to samples-per-beat, where the last split sample and the next load share one clock edge. The bench reaches it with a 32-bit bus carrying 8-bit real words at ratio 4.

// File: rtl/sia_pkg.sv
`timescale 1ns/1ps
package sia_pkg;
   localparam int unsigned SIA_BUS_W   = 32;
   localparam int unsigned SIA_WORD_W  = 16;
   localparam int unsigned SIA_MIN_BUS = 4;
   localparam int unsigned SIA_MIN_SMP = 8;
   localparam int unsigned SIA_BC_W    = $clog2(SIA_BUS_W / SIA_MIN_BUS);
   localparam int unsigned SIA_K_W     = $clog2(SIA_BUS_W / SIA_MIN_SMP + 1);

   typedef enum logic [1:0] {
      STG_ENCODER = 2'd0,
      STG_SHAPER  = 2'd1,
      STG_BYPASS  = 2'd2,
      STG_RSVD    = 2'd3
   } stage_e;

   typedef struct packed {
      logic [2:0] lg_bus;
      logic [2:0] lg_smp;
      logic       word16;
      logic       cplx;
   } eff_cfg_t;
endpackage

// File: rtl/sia_cfg.sv
`timescale 1ns/1ps
module sia_cfg
   import sia_pkg::*;
#(
   parameter int unsigned CH_W  = 2,
   parameter int unsigned DIV_W = 8
) (
   input  logic                upconv_mode,
   input  logic [1:0]          bus_sel,
   input  logic                word16,
   input  logic                cplx,
   input  logic [1:0]          first_stage,
   input  logic [CH_W-1:0]     nch_m1,
   input  logic [DIV_W-1:0]    div_ratio,
   output eff_cfg_t            eff,
   output logic [CH_W-1:0]     nch_eff,
   output logic [SIA_BC_W-1:0] bps_m1,
   output logic [SIA_K_W-1:0]  kcnt,
   output logic                cfg_err
);
   logic [3:0] span;
   logic       stage_ok;

   always_comb begin
      eff = '0;
      if (upconv_mode) begin
         eff.lg_bus = 3'd5;
         eff.word16 = 1'b1;
         eff.cplx   = 1'b1;
         nch_eff    = '0;
      end else begin
         eff.lg_bus = 3'd2 + {1'b0, bus_sel};
         eff.word16 = word16;
         eff.cplx   = cplx;
         nch_eff    = nch_m1;
      end
      eff.lg_smp = 3'd3 + {2'b0, eff.word16} + {2'b0, eff.cplx};

      if (eff.lg_smp >= eff.lg_bus) begin
         span   = 4'd1 << (eff.lg_smp - eff.lg_bus);
         bps_m1 = SIA_BC_W'(span - 4'd1);
         kcnt   = SIA_K_W'(1);
      end else begin
         span   = 4'd1 << (eff.lg_bus - eff.lg_smp);
         bps_m1 = '0;
         kcnt   = SIA_K_W'(span);
      end

      case (first_stage)
         STG_ENCODER: stage_ok = !word16 && !cplx;
         STG_SHAPER:  stage_ok = !word16 &&  cplx;
         STG_BYPASS:  stage_ok =  word16 &&  cplx;
         default:     stage_ok = 1'b0;
      endcase

      cfg_err = (!upconv_mode && !stage_ok)
              || (div_ratio < DIV_W'(2))
              || (div_ratio < DIV_W'(kcnt));
   end
endmodule

// File: rtl/sia_clkdiv.sv
`timescale 1ns/1ps
module sia_clkdiv #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] ratio,
   output logic             dco,
   output logic             cap
);
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt == ratio - DIV_W'(1));
   assign cap  = run && wrap;
   assign dco  = run && (cnt < (ratio >> 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (wrap)      cnt <= '0;
      else                cnt <= cnt + DIV_W'(1);
   end

   // R4: the phase counter stays inside the programmed period
   a_r4_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < ratio));
endmodule

// File: rtl/sia_pack.sv
`timescale 1ns/1ps
module sia_pack
   import sia_pkg::*;
#(
   parameter int unsigned BUS_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                cap,
   input  logic [BUS_W-1:0]    bus_data,
   input  logic [2:0]          lg_bus,
   input  logic [SIA_BC_W-1:0] bps_m1,
   output logic                fsync,
   output logic                load,
   output logic [BUS_W-1:0]    load_word
);
   localparam int unsigned NWID = 4;

   logic [BUS_W-1:0]    beat_w [NWID];
   logic [BUS_W-1:0]    beat;
   logic [BUS_W-1:0]    acc;
   logic [BUS_W-1:0]    acc_nx;
   logic [SIA_BC_W-1:0] bcnt;
   logic [1:0]          wsel;
   logic [5:0]          bw;
   logic [5:0]          sh;

   for (genvar g = 0; g < NWID; g++) begin : g_width
      localparam logic [BUS_W-1:0] MASK = BUS_W'((64'd1 << (SIA_MIN_BUS << g)) - 64'd1);
      assign beat_w[g] = bus_data & MASK;
   end

   assign wsel      = 2'(lg_bus - 3'd2);
   assign beat      = beat_w[wsel];
   assign bw        = 6'd1 << lg_bus;
   assign sh        = 6'(6'(bcnt) * bw);
   assign acc_nx    = acc | (beat << sh);
   assign load      = cap && (bcnt == bps_m1);
   assign load_word = acc_nx;
   assign fsync     = run && (bcnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         bcnt <= '0;
         acc  <= '0;
      end else if (cap) begin
         if (bcnt == bps_m1) begin
            bcnt <= '0;
            acc  <= '0;
         end else begin
            bcnt <= bcnt + SIA_BC_W'(1);
            acc  <= acc_nx;
         end
      end
   end

   // R6: the beat position, and so fsync, moves only on a capture
   a_r6_beat_pos_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cap) |=> (bcnt == $past(bcnt)));
endmodule

// File: rtl/sia_emit.sv
`timescale 1ns/1ps
module sia_emit
   import sia_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CH_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               load,
   input  logic [BUS_W-1:0]   load_word,
   input  logic [2:0]         lg_smp,
   input  logic               word16,
   input  logic               cplx,
   input  logic [SIA_K_W-1:0] kcnt,
   input  logic [CH_W-1:0]    nch_m1,
   output logic               smp_valid,
   output logic [WORD_W-1:0]  smp_i,
   output logic [WORD_W-1:0]  smp_q,
   output logic [CH_W-1:0]    smp_ch
);
   localparam int unsigned HW = WORD_W / 2;

   logic [BUS_W-1:0]   pend;
   logic [SIA_K_W-1:0] rem;
   logic [5:0]         sw;

   assign sw        = 6'd1 << lg_smp;
   assign smp_valid = run && (rem != '0);

   always_comb begin
      if (word16) smp_i = pend[WORD_W-1:0];
      else        smp_i = {{HW{1'b0}}, pend[HW-1:0]};
      if (!cplx)       smp_q = '0;
      else if (word16) smp_q = pend[2*WORD_W-1:WORD_W];
      else             smp_q = {{HW{1'b0}}, pend[WORD_W-1:HW]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pend   <= '0;
         rem    <= '0;
         smp_ch <= '0;
      end else begin
         if (load) begin
            pend <= load_word;
            rem  <= kcnt;
         end else if (smp_valid) begin
            pend <= pend >> sw;
            rem  <= rem - SIA_K_W'(1);
         end
         if (smp_valid) smp_ch <= (smp_ch == nch_m1) ? '0 : smp_ch + CH_W'(1);
      end
   end

   // R7: never more pending samples than one beat holds
   a_r7_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (rem <= kcnt));
   // R9: channel index stays within the active channel count
   a_r9_channel_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (smp_ch <= nch_m1));
   // R3: an idle cycle leaves nothing pending and the channel back at 0
   a_r3_idle_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ((rem == '0) && (smp_ch == '0)));
endmodule

// File: rtl/sample_input_assembler.sv
`timescale 1ns/1ps
module sample_input_assembler
   import sia_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned MAX_CH = 4,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              upconv_mode,
   input  logic [1:0]        bus_sel,
   input  logic              word16,
   input  logic              cplx,
   input  logic [1:0]        first_stage,
   input  logic [$clog2(MAX_CH)-1:0] nch_m1,
   input  logic [DIV_W-1:0]  div_ratio,
   input  logic [BUS_W-1:0]  bus_data,
   output logic              dco,
   output logic              fsync,
   output logic              smp_valid,
   output logic [WORD_W-1:0] smp_i,
   output logic [WORD_W-1:0] smp_q,
   output logic [$clog2(MAX_CH)-1:0] smp_ch,
   output logic              cfg_err
);
   localparam int unsigned CH_W  = $clog2(MAX_CH);
   localparam int unsigned RAW_W = 7 + CH_W + DIV_W;

   if (BUS_W != SIA_BUS_W)   begin : g_bad_bus  $error("BUS_W must be 32");   end
   if (WORD_W != SIA_WORD_W) begin : g_bad_word $error("WORD_W must be 16");  end
   if (MAX_CH != 2 && MAX_CH != 4) begin : g_bad_ch $error("MAX_CH must be 2 or 4"); end
   if (DIV_W < SIA_K_W + 1)  begin : g_bad_div  $error("DIV_W too narrow");  end

   eff_cfg_t            eff;
   logic [CH_W-1:0]     nch_eff;
   logic [SIA_BC_W-1:0] bps_m1;
   logic [SIA_K_W-1:0]  kcnt;
   logic [RAW_W-1:0]    raw, raw_q;
   logic                run, cap, load;
   logic [BUS_W-1:0]    load_word;

   assign raw = {upconv_mode, bus_sel, word16, cplx, first_stage, nch_m1, div_ratio};
   assign run = en && !cfg_err && (raw == raw_q);

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw;
   end

   sia_cfg #(.CH_W(CH_W), .DIV_W(DIV_W)) u_cfg (
      .upconv_mode (upconv_mode),
      .bus_sel     (bus_sel),
      .word16      (word16),
      .cplx        (cplx),
      .first_stage (first_stage),
      .nch_m1      (nch_m1),
      .div_ratio   (div_ratio),
      .eff         (eff),
      .nch_eff     (nch_eff),
      .bps_m1      (bps_m1),
      .kcnt        (kcnt),
      .cfg_err     (cfg_err)
   );

   sia_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .ratio (div_ratio),
      .dco   (dco),
      .cap   (cap)
   );

   sia_pack #(.BUS_W(BUS_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .cap       (cap),
      .bus_data  (bus_data),
      .lg_bus    (eff.lg_bus),
      .bps_m1    (bps_m1),
      .fsync     (fsync),
      .load      (load),
      .load_word (load_word)
   );

   sia_emit #(.BUS_W(BUS_W), .WORD_W(WORD_W), .CH_W(CH_W)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .load      (load),
      .load_word (load_word),
      .lg_smp    (eff.lg_smp),
      .word16    (eff.word16),
      .cplx      (eff.cplx),
      .kcnt      (kcnt),
      .nch_m1    (nch_eff),
      .smp_valid (smp_valid),
      .smp_i     (smp_i),
      .smp_q     (smp_q),
      .smp_ch    (smp_ch)
   );

   // R10: the upconverter mode never reports a channel other than 0
   a_r10_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
      (upconv_mode && smp_valid) |-> (smp_ch == '0));
endmodule

// File: tb/sim_sample_input_assembler.sv
`timescale 1ns/1ps
module sim_sample_input_assembler;
   logic clk = 1'b0;
   logic rst_n, en, upconv, word16, cplx;
   logic [1:0] bus_sel, stage, nch_m1;
   logic [7:0] ratio;
   logic [31:0] bus_data;

   logic n_rst, n_en, n_up, n_w16, n_cx;
   logic [1:0] n_bs, n_stg, n_nch;
   logic [7:0] n_ratio;

   logic dco, fsync, smp_valid, cfg_err;
   logic [15:0] smp_i, smp_q;
   logic [1:0] smp_ch;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string ctx = "";
   string err_tag = "R2";

   int m_cnt, m_bcnt, m_ch;
   logic [31:0] m_acc;
   logic [31:0] m_q[$];
   logic p_up, p_w16, p_cx;
   logic [1:0] p_bs, p_stg, p_nch;
   logic [7:0] p_ratio;

   sample_input_assembler u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .upconv_mode(upconv), .bus_sel(bus_sel),
      .word16(word16), .cplx(cplx), .first_stage(stage), .nch_m1(nch_m1),
      .div_ratio(ratio), .bus_data(bus_data), .dco(dco), .fsync(fsync),
      .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q), .smp_ch(smp_ch),
      .cfg_err(cfg_err)
   );

   always #2 clk = ~clk;

   function automatic void eff(output int lb, output int ls, output int w, output int cx,
                               output int nch, output int bps, output int k);
      if (upconv) begin lb = 5; w = 16; cx = 1; nch = 1; end
      else begin lb = 2 + int'(bus_sel); w = word16 ? 16 : 8; cx = int'(cplx); nch = int'(nch_m1) + 1; end
      ls  = (w == 16 ? 4 : 3) + cx;
      bps = (ls >= lb) ? (1 << (ls - lb)) : 1;
      k   = (ls >  lb) ? 1 : (1 << (lb - ls));
   endfunction

   function automatic bit f_err();
      int lb, ls, w, cx, nch, bps, k;
      bit ok;
      eff(lb, ls, w, cx, nch, bps, k);
      if (upconv) ok = 1;
      else case (stage)
         2'd0: ok = !word16 && !cplx;
         2'd1: ok = !word16 && cplx;
         2'd2: ok = word16 && cplx;
         default: ok = 0;
      endcase
      return !ok || (int'(ratio) < 2) || (int'(ratio) < k);
   endfunction

   function automatic bit f_run();
      bit same;
      same = (upconv == p_up) && (bus_sel == p_bs) && (word16 == p_w16) && (cplx == p_cx)
          && (stage == p_stg) && (nch_m1 == p_nch) && (ratio == p_ratio);
      return en && !f_err() && same;
   endfunction

   task automatic m_clear();
      m_cnt = 0; m_bcnt = 0; m_ch = 0; m_acc = '0; m_q.delete();
   endtask

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      int lb, ls, w, cx, nch, bps, k, bb, ss;
      logic [31:0] beat;
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL R3 watchdog: got %0d cycles exp below 20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
      if (!rst_n) begin
         m_clear();
         p_up = 0; p_bs = 0; p_w16 = 0; p_cx = 0; p_stg = 0; p_nch = 0; p_ratio = 0;
      end else begin
         eff(lb, ls, w, cx, nch, bps, k);
         if (!f_run()) m_clear();
         else begin
            if (m_q.size() > 0) begin
               void'(m_q.pop_front());
               m_ch = (m_ch == nch - 1) ? 0 : m_ch + 1;
            end
            if (m_cnt == int'(ratio) - 1) begin
               bb = 1 << lb; ss = 1 << ls;
               beat = (bb == 32) ? bus_data : (bus_data & ((32'd1 << bb) - 32'd1));
               if (bps == 1) begin
                  for (int j = 0; j < k; j++)
                     m_q.push_back((ss == 32) ? beat : ((beat >> (j * ss)) & ((32'd1 << ss) - 32'd1)));
               end else begin
                  m_acc = m_acc | (beat << (m_bcnt * bb));
                  if (m_bcnt == bps - 1) begin
                     m_q.push_back(m_acc); m_acc = '0; m_bcnt = 0;
                  end else m_bcnt++;
               end
               m_cnt = 0;
            end else m_cnt++;
         end
         p_up = upconv; p_bs = bus_sel; p_w16 = word16; p_cx = cplx;
         p_stg = stage; p_nch = nch_m1; p_ratio = ratio;
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s [%s]: got %0h exp %0h", req, what, ctx, act, exp);
      end
   endtask

   task automatic compare();
      int lb, ls, w, cx, nch, bps, k;
      bit r, e_v;
      logic [31:0] s, wm, ei, eq;
      eff(lb, ls, w, cx, nch, bps, k);
      r   = rst_n ? f_run() : (en && !f_err() && upconv == 0 && bus_sel == 0 && word16 == 0
                               && cplx == 0 && stage == 0 && nch_m1 == 0 && ratio == 0);
      e_v = r && (m_q.size() > 0);
      chk("R4", "dco", 32'(dco), 32'(r && (m_cnt < int'(ratio) / 2)));
      chk("R6", "fsync", 32'(fsync), 32'(r && (m_bcnt == 0)));
      chk("R7", "smp_valid", 32'(smp_valid), 32'(e_v));
      chk(err_tag, "cfg_err", 32'(cfg_err), 32'(f_err()));
      if (e_v) begin
         s  = m_q[0];
         wm = (32'd1 << w) - 32'd1;
         ei = s & wm;
         eq = cx ? ((s >> w) & wm) : 32'd0;
         chk("R5", "smp_i", 32'(smp_i), ei);
         chk("R8", "smp_q", 32'(smp_q), eq);
         chk("R9", "smp_ch", 32'(smp_ch), 32'(m_ch));
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rst_n = n_rst; en = n_en; upconv = n_up; bus_sel = n_bs; word16 = n_w16;
         cplx = n_cx; stage = n_stg; nch_m1 = n_nch; ratio = n_ratio;
         bus_data = $urandom;
         #1;
         compare();
      end
   endtask

   task automatic setc(logic up, logic [1:0] bs, logic w16, logic cx, logic [1:0] stg,
                       logic [1:0] nch, logic [7:0] rt);
      n_up = up; n_bs = bs; n_w16 = w16; n_cx = cx; n_stg = stg; n_nch = nch; n_ratio = rt;
   endtask

   initial begin
      n_rst = 0; n_en = 0;
      setc(0, 2'd0, 1, 1, 2'd2, 2'd3, 8'd3);
      rst_n = 0; en = 0; upconv = 0; bus_sel = 0; word16 = 1; cplx = 1; stage = 2;
      nch_m1 = 3; ratio = 3; bus_data = '0;
      ctx = "R1 reset";
      step(4);
      // R1: quiet outputs while held in reset
      chk("R1", "dco", 32'(dco), 0);
      chk("R1", "fsync", 32'(fsync), 0);
      chk("R1", "smp_valid", 32'(smp_valid), 0);
      chk("R1", "smp_ch", 32'(smp_ch), 0);
      n_rst = 1;
      ctx = "R5 16-bit complex on 4-bit bus, four channels"; n_en = 1;
      step(200);
      ctx = "R7 8-bit real split from 32-bit bus at ratio 4";
      setc(0, 2'd3, 0, 0, 2'd0, 2'd2, 8'd4); step(80);
      ctx = "R8 8-bit complex on 8-bit bus at ratio 2";
      setc(0, 2'd1, 0, 1, 2'd1, 2'd1, 8'd2); step(60);
      ctx = "R9 single channel, 16-bit bus, ratio 5";
      setc(0, 2'd2, 0, 0, 2'd0, 2'd0, 8'd5); step(60);
      err_tag = "R2"; ctx = "R3 encoder with 16-bit words";
      setc(0, 2'd2, 1, 0, 2'd0, 2'd0, 8'd5); step(12);
      ctx = "R3 reserved stage code";
      setc(0, 2'd2, 1, 1, 2'd3, 2'd0, 8'd5); step(12);
      err_tag = "R12"; ctx = "R3 ratio below samples per beat";
      setc(0, 2'd3, 0, 0, 2'd0, 2'd0, 8'd3); step(12);
      ctx = "R3 ratio of one";
      setc(0, 2'd0, 1, 1, 2'd2, 2'd0, 8'd1); step(12);
      err_tag = "R2";
      ctx = "R10 upconverter ignores width inputs";
      setc(1, 2'd0, 0, 0, 2'd3, 2'd3, 8'd2); step(60);
      setc(1, 2'd1, 1, 0, 2'd0, 2'd2, 8'd6); step(60);
      ctx = "R3 enable dropped mid-run";
      setc(0, 2'd0, 1, 1, 2'd2, 2'd3, 8'd3); step(31);
      n_en = 0; step(10);
      n_en = 1; step(40);
      ctx = "R11 channel count changed mid-sample";
      step(17);
      n_nch = 2'd1; step(60);
      ctx = "R11 ratio changed mid-sample";
      step(5);
      n_ratio = 8'd4; step(80);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule